// File: doc/BRIEF.md
# UART FIFO and Interrupt Controller

This block sits between a serial line engine and a register bus. It buffers outgoing bytes in a 16-entry transmit queue and incoming characters in a 16-entry receive queue. Each receive entry is ten bits: the byte plus a parity-error flag and a framing-error flag. Software fills the transmit queue and empties the receive queue through two fixed addresses. The serializer takes bytes over a valid/ready stream. The deserializer delivers characters over a second valid/ready stream. The serial framing and the baud timing live outside this block.

Queue events, line events and error events collect in a 14-bit sticky status register. Each bit is cleared by writing a 1 to it. An enable mask selects which bits drive the active-high `irq` output. A control register turns the queues on and flushes either queue with a bit that clears itself. A single index register reports both fill levels.

Stream rules: `tx_valid` is high while the queues are enabled and the transmit queue holds data, and a byte leaves on each cycle with `tx_valid && tx_ready`. `rx_ready` is tied high, so the receive side never applies back-pressure. A character offered while the receive queue is full is discarded and flagged instead.

Register map (byte addresses): interrupt enable 0x014, interrupt status 0x018, queue control 0x020, fill index 0x024, transmit queue write 0x1000, receive queue read 0x1020. Register reads are combinational, from `reg_addr` in the same cycle. Unmapped addresses read 0.

Top module: `uart_fifo_irq_ctl`

## Requirements
- R1: After reset, the enable, status, control and index registers all read 0, `irq` is low and `tx_valid` is low.
- R2: Control bit 0 enables the queues. While it is 0, writes to 0x1000 and characters on the receive stream are ignored and `tx_valid` stays low. While it is 1, bytes leave on `tx_data` in the order they were written, one per `tx_valid && tx_ready` cycle.
- R3: A write to 0x1000 while the transmit queue holds 16 bytes is discarded. The stored bytes are kept, and status bit 6 (transmit underrun/overflow) is set.
- R4: A read of 0x1020 returns the oldest receive entry and removes it. The entry has the byte in bits [7:0], the parity flag in bit 8 and the framing flag in bit 9. A read of an empty receive queue returns 0 and changes nothing.
- R5: `rx_ready` is always high. A character offered while the receive queue holds 16 entries is dropped, and status bit 7 (receive overrun) is set.
- R6: The index register at 0x024 holds the transmit count (0 to 16) in bits [4:0] and the receive count (0 to 16) in bits [12:8]. All other bits read 0.
- R7: Bit 0 is set for each byte taken by the serializer, and bit 1 for each character stored. The following bits are set only when their condition becomes true: bit 2 when the transmit count falls to 4 or less, bit 3 when the transmit count becomes 0, bit 4 when the receive count reaches 12 or more, and bit 5 when the receive count reaches 16.
- R8: A stored character with its parity flag sets bit 8. A stored character with its framing flag sets bit 9.
- R9: Bit 11 is set on the 4th `char_tick` counted while the receive queue is non-empty and no character has arrived. Each stored character restarts the count.
- R10: A pulse on `cts_toggle` sets bit 10, a pulse on `break_done` sets bit 12, and a pulse on `bus_error` sets bit 13.
- R11: Writing 0x018 clears each status bit written as 1 and leaves bits written as 0. When a bit is set and cleared in the same cycle, it ends up set.
- R12: `irq` is high exactly when some status bit and its bit in the enable register (0x014) are both 1.
- R13: Control bits 2 and 3 flush the transmit queue and the receive queue, respectively. Each reads back as 1 for the cycle after the write, and then clears itself as its queue empties. The enable bit is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a receive entry at 0x1020) |
| reg_addr | input | 13 | Byte address |
| reg_wdata | input | 14 | Write data |
| reg_rdata | output | 14 | Read data, combinational from `reg_addr` |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error on this character |
| rx_frm_err | input | 1 | Framing error on this character |
| char_tick | input | 1 | One pulse per character time |
| cts_toggle | input | 1 | Clear-to-send changed |
| break_done | input | 1 | Break transmission finished |
| bus_error | input | 1 | Bus error response seen |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: 16-entry queues, an almost-empty level of 4, an almost-full level of 12 and a timeout of 4 character times. These values let a handful of directed writes and characters fill both queues to the brim, push one past full, and cross each watermark in both directions. The timeout is short enough to show that the bit stays clear after three ticks and is set on the fourth.

// File: rtl/uart_fic_pkg.sv
package uart_fic_pkg;
  localparam int BUS_W  = 14;
  localparam int ADDR_W = 13;
  localparam int CHAR_W = 8;
  localparam int NUM_EV = 14;

  localparam logic [ADDR_W-1:0] A_IE  = 13'h0014;
  localparam logic [ADDR_W-1:0] A_IS  = 13'h0018;
  localparam logic [ADDR_W-1:0] A_FC  = 13'h0020;
  localparam logic [ADDR_W-1:0] A_IDX = 13'h0024;
  localparam logic [ADDR_W-1:0] A_TXQ = 13'h1000;
  localparam logic [ADDR_W-1:0] A_RXQ = 13'h1020;

  // status bit positions (software decodes these)
  localparam int EV_TXDE   = 0;
  localparam int EV_RXDF   = 1;
  localparam int EV_TXAE   = 2;
  localparam int EV_TXE    = 3;
  localparam int EV_RXAF   = 4;
  localparam int EV_RXF    = 5;
  localparam int EV_TXOVF  = 6;
  localparam int EV_RXOVR  = 7;
  localparam int EV_PAR    = 8;
  localparam int EV_FRM    = 9;
  localparam int EV_CTS    = 10;
  localparam int EV_RXTO   = 11;
  localparam int EV_BRK    = 12;
  localparam int EV_BUSERR = 13;

  localparam int IDX_RX_LSB = 8;

  typedef struct packed {
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/ufic_fifo.sv
module ufic_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == FULL_C);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ufic_rise.sv
module ufic_rise #(
  parameter int           N    = 1,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= INIT[i];
      else        prev_q[i] <= cond[i];
    end
    assign rise[i] = cond[i] && !prev_q[i];
  end
endmodule

// File: rtl/ufic_rx_timeout.sv
module ufic_rx_timeout #(
  parameter int TO_CHARS = 4,
  localparam int CW = $clog2(TO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_nonempty,
  input  logic rx_push,
  input  logic char_tick,
  output logic fire
);
  localparam logic [CW-1:0] LIM    = CW'(TO_CHARS);
  localparam logic [CW-1:0] LIM_M1 = CW'(TO_CHARS - 1);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idle_q <= '0;
    else if (rx_push || !rx_nonempty) idle_q <= '0;
    else if (char_tick && idle_q != LIM) idle_q <= idle_q + 1'b1;
  end

  assign fire = char_tick && rx_nonempty && !rx_push && (idle_q == LIM_M1);
endmodule

// File: rtl/ufic_events.sv
module ufic_events #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | set_vec;
  end

  assign irq = |(stat & mask);
endmodule

// File: rtl/uart_fifo_irq_ctl.sv
module uart_fifo_irq_ctl
  import uart_fic_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AE_LEVEL = 4,
  parameter int AF_LEVEL = 12,
  parameter int TO_CHARS = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RXE_W = $bits(rx_entry_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              char_tick,
  input  logic              cts_toggle,
  input  logic              break_done,
  input  logic              bus_error,
  output logic              irq
);
  localparam logic [CNT_W-1:0] AE_L = CNT_W'(AE_LEVEL);
  localparam logic [CNT_W-1:0] AF_L = CNT_W'(AF_LEVEL);

  logic              fifo_en_q, tx_rst_pend, rx_rst_pend;
  logic [NUM_EV-1:0] ie_q, isr_q, set_vec, clr_vec;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_req, tx_push, tx_pop, rx_push, rx_pop;
  rx_entry_t         rx_in, rx_head;
  logic [3:0]        lvl_cond, lvl_rise;
  logic              to_fire;

  // register decode
  logic ie_wr, is_wr, fc_wr;
  assign ie_wr = reg_wr && (reg_addr == A_IE);
  assign is_wr = reg_wr && (reg_addr == A_IS);
  assign fc_wr = reg_wr && (reg_addr == A_FC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= '0;
      fifo_en_q   <= 1'b0;
      tx_rst_pend <= 1'b0;
      rx_rst_pend <= 1'b0;
    end else begin
      if (ie_wr) ie_q <= reg_wdata[NUM_EV-1:0];
      if (fc_wr) begin
        fifo_en_q   <= reg_wdata[0];
        tx_rst_pend <= reg_wdata[2];
        rx_rst_pend <= reg_wdata[3];
      end else begin
        tx_rst_pend <= 1'b0;
        rx_rst_pend <= 1'b0;
      end
    end
  end

  // transmit side
  assign tx_req   = reg_wr && (reg_addr == A_TXQ) && fifo_en_q;
  assign tx_push  = tx_req && !tx_full;
  assign tx_valid = fifo_en_q && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;

  ufic_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_rst_pend),
    .push(tx_push), .din(reg_wdata[CHAR_W-1:0]),
    .pop(tx_pop), .dout(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  // receive side
  assign rx_ready = 1'b1;
  assign rx_push  = rx_valid && fifo_en_q && !rx_full;
  assign rx_pop   = reg_rd && (reg_addr == A_RXQ) && !rx_empty;
  assign rx_in    = '{frm: rx_frm_err, par: rx_par_err, data: rx_data};

  ufic_fifo #(.W(RXE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_rst_pend),
    .push(rx_push), .din(rx_in),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // watermark conditions: {rx full, rx almost full, tx empty, tx almost empty}
  assign lvl_cond = {rx_full, (rx_cnt >= AF_L), tx_empty, (tx_cnt <= AE_L)};

  ufic_rise #(.N(4), .INIT(4'b0011)) u_lvl (
    .clk(clk), .rst_n(rst_n), .cond(lvl_cond), .rise(lvl_rise)
  );

  ufic_rx_timeout #(.TO_CHARS(TO_CHARS)) u_to (
    .clk(clk), .rst_n(rst_n), .rx_nonempty(!rx_empty),
    .rx_push(rx_push), .char_tick(char_tick), .fire(to_fire)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[EV_TXDE]   = tx_pop;
    set_vec[EV_RXDF]   = rx_push;
    set_vec[EV_TXAE]   = lvl_rise[0];
    set_vec[EV_TXE]    = lvl_rise[1];
    set_vec[EV_RXAF]   = lvl_rise[2];
    set_vec[EV_RXF]    = lvl_rise[3];
    set_vec[EV_TXOVF]  = tx_req && tx_full;
    set_vec[EV_RXOVR]  = rx_valid && fifo_en_q && rx_full;
    set_vec[EV_PAR]    = rx_push && rx_par_err;
    set_vec[EV_FRM]    = rx_push && rx_frm_err;
    set_vec[EV_CTS]    = cts_toggle;
    set_vec[EV_RXTO]   = to_fire;
    set_vec[EV_BRK]    = break_done;
    set_vec[EV_BUSERR] = bus_error;
  end

  assign clr_vec = is_wr ? reg_wdata[NUM_EV-1:0] : '0;

  ufic_events #(.N(NUM_EV)) u_ev (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask(ie_q), .stat(isr_q), .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_IE:  reg_rdata[NUM_EV-1:0] = ie_q;
      A_IS:  reg_rdata[NUM_EV-1:0] = isr_q;
      A_FC: begin
        reg_rdata[0] = fifo_en_q;
        reg_rdata[2] = tx_rst_pend;
        reg_rdata[3] = rx_rst_pend;
      end
      A_IDX: begin
        reg_rdata[CNT_W-1:0]              = tx_cnt;
        reg_rdata[IDX_RX_LSB +: CNT_W]    = rx_cnt;
      end
      A_RXQ: if (!rx_empty) reg_rdata[RXE_W-1:0] = rx_head;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ufic_checker.sv
module ufic_checker
  import uart_fic_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              fifo_en_q,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [NUM_EV-1:0] isr_q,
  input logic [NUM_EV-1:0] ie_q,
  input logic              tx_rst_pend,
  input logic              rx_rst_pend,
  input logic              irq
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL_C);

  assert_rx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL_C);

  assert_tx_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXQ && fifo_en_q && tx_cnt == FULL_C) |=> isr_q[EV_TXOVF]);

  assert_rx_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fifo_en_q && rx_cnt == FULL_C) |=> isr_q[EV_RXOVR]);

  assert_rx_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);

  assert_tx_flush_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rst_pend && !reg_wr) |=> (!tx_rst_pend && tx_cnt == '0));

  assert_rx_flush_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst_pend && !reg_wr) |=> (!rx_rst_pend && rx_cnt == '0));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);
endmodule

bind uart_fifo_irq_ctl ufic_checker #(.DEPTH(DEPTH)) u_ufic_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .fifo_en_q(fifo_en_q), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .isr_q(isr_q), .ie_q(ie_q),
  .tx_rst_pend(tx_rst_pend), .rx_rst_pend(rx_rst_pend), .irq(irq)
);

// File: tb/tb_uart_fifo_irq_ctl.sv
module tb_uart_fifo_irq_ctl;
  localparam logic [12:0] A_IE = 13'h0014, A_IS = 13'h0018, A_FC = 13'h0020,
                          A_IDX = 13'h0024, A_TXQ = 13'h1000, A_RXQ = 13'h1020;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [12:0] reg_addr = '0;
  logic [13:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid, tx_ready = 0, rx_ready, irq;
  logic [7:0]  tx_data, rx_data = '0;
  logic        rx_valid = 0, rx_par_err = 0, rx_frm_err = 0;
  logic        char_tick = 0, cts_toggle = 0, break_done = 0, bus_error = 0;
  int          n_chk = 0, n_fail = 0;
  logic [13:0] rv;

  always #5 clk = ~clk;

  uart_fifo_irq_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .char_tick(char_tick),
    .cts_toggle(cts_toggle), .break_done(break_done), .bus_error(bus_error),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [13:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [13:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rx_send(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_par_err = p; rx_frm_err = f;
    @(negedge clk); rx_valid = 0; rx_par_err = 0; rx_frm_err = 0;
  endtask

  task automatic tx_take(output logic [7:0] d);
    @(negedge clk); d = tx_data; tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic clear_all();
    wr(A_IS, 14'h3fff);
  endtask

  task automatic t_reset();
    rd(A_IDX, rv); chk("R1 idx", rv, 0);
    rd(A_IS, rv);  chk("R1 status", rv, 0);
    rd(A_FC, rv);  chk("R1 control", rv, 0);
    rd(A_IE, rv);  chk("R1 enable", rv, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_disabled();
    wr(A_TXQ, 14'h5a);
    rx_send(8'h33, 0, 0);
    rd(A_IDX, rv); chk("R2 disabled counts", rv, 0);
    chk("R2 disabled tx_valid", tx_valid, 0);
    rd(A_IS, rv); chk("R2 disabled no events", rv, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b;
    wr(A_FC, 14'h1);
    wr(A_TXQ, 14'h11); wr(A_TXQ, 14'h22); wr(A_TXQ, 14'h33);
    rd(A_IDX, rv); chk("R6 idx tx=3", rv, 14'h0003);
    chk("R2 tx_valid", tx_valid, 1);
    tx_take(b); chk("R2 order 0", b, 8'h11);
    rd(A_IDX, rv); chk("R6 idx tx=2", rv, 14'h0002);
    tx_take(b); chk("R2 order 1", b, 8'h22);
    tx_take(b); chk("R2 order 2", b, 8'h33);
    rd(A_IS, rv);
    chk("R7 tx data empty bit0", rv[0], 1);
    chk("R7 tx empty bit3", rv[3], 1);
    chk("R7 no almost-empty edge bit2", rv[2], 0);
    chk("R2 tx_valid idle", tx_valid, 0);
    clear_all();
    rd(A_IS, rv); chk("R11 cleared", rv, 0);
  endtask

  task automatic t_tx_full();
    logic [7:0] b;
    for (int i = 0; i < 16; i++) wr(A_TXQ, 14'(8'h40 + i));
    clear_all();
    wr(A_TXQ, 14'hee);
    rd(A_IS, rv); chk("R3 overflow bit6", rv[6], 1);
    rd(A_IDX, rv); chk("R3 count stays 16", rv, 14'h0010);
    for (int i = 0; i < 11; i++) begin
      tx_take(b); chk("R3 order kept", b, 8'h40 + i);
    end
    rd(A_IS, rv); chk("R7 almost-empty at 5", rv[2], 0);
    tx_take(b); chk("R3 order kept", b, 8'h4b);
    rd(A_IS, rv); chk("R7 almost-empty at 4", rv[2], 1);
    for (int i = 12; i < 16; i++) begin
      tx_take(b); chk("R3 order kept", b, 8'h40 + i);
    end
    chk("R3 overflow byte dropped", tx_valid, 0);
    clear_all();
  endtask

  task automatic t_rx();
    rx_send(8'h41, 0, 0); rx_send(8'h42, 1, 0); rx_send(8'h43, 0, 1);
    rd(A_IDX, rv); chk("R6 idx rx=3", rv, 14'h0300);
    rd(A_IS, rv);
    chk("R7 rx stored bit1", rv[1], 1);
    chk("R8 parity bit8", rv[8], 1);
    chk("R8 framing bit9", rv[9], 1);
    chk("R7 no almost-full bit4", rv[4], 0);
    rd(A_RXQ, rv); chk("R4 entry 0", rv, 14'h041);
    rd(A_RXQ, rv); chk("R4 entry 1 parity", rv, 14'h142);
    rd(A_RXQ, rv); chk("R4 entry 2 framing", rv, 14'h243);
    rd(A_RXQ, rv); chk("R4 empty read", rv, 0);
    rd(A_IDX, rv); chk("R4 empty read no change", rv, 0);
    clear_all();
  endtask

  task automatic t_rx_full();
    for (int i = 0; i < 11; i++) rx_send(8'(i), 0, 0);
    rd(A_IS, rv); chk("R7 almost-full at 11", rv[4], 0);
    rx_send(8'd11, 0, 0);
    rd(A_IS, rv); chk("R7 almost-full at 12", rv[4], 1);
    for (int i = 12; i < 16; i++) rx_send(8'(i), 0, 0);
    rd(A_IS, rv);
    chk("R7 rx full bit5", rv[5], 1);
    chk("R5 no overrun yet", rv[7], 0);
    chk("R5 rx_ready", rx_ready, 1);
    rx_send(8'hff, 0, 0);
    rd(A_IS, rv); chk("R5 overrun bit7", rv[7], 1);
    rd(A_IDX, rv); chk("R5 count 16", rv, 14'h1000);
    for (int i = 0; i < 16; i++) begin
      rd(A_RXQ, rv); chk("R5 kept entries", rv, 14'(i));
    end
    rd(A_RXQ, rv); chk("R5 dropped char absent", rv, 0);
    clear_all();
  endtask

  task automatic t_irq_line();
    @(negedge clk); cts_toggle = 1; @(negedge clk); cts_toggle = 0;
    rd(A_IS, rv); chk("R10 cts bit10", rv, 14'h0400);
    chk("R12 masked irq low", irq, 0);
    wr(A_IE, 14'h0400);
    chk("R12 irq high", irq, 1);
    wr(A_IE, 14'h0800);
    chk("R12 other mask low", irq, 0);
    @(negedge clk); break_done = 1; bus_error = 1;
    @(negedge clk); break_done = 0; bus_error = 0;
    rd(A_IS, rv); chk("R10 break and bus error", rv, 14'h3400);
    wr(A_IS, 14'h1000);
    rd(A_IS, rv); chk("R11 w1c selective", rv, 14'h2400);
    wr(A_IS, 14'h0000);
    rd(A_IS, rv); chk("R11 zero write no effect", rv, 14'h2400);
    wr(A_IS, 14'h0400);
    @(negedge clk); reg_wr = 1; reg_addr = A_IS; reg_wdata = 14'h2000; bus_error = 1;
    @(negedge clk); reg_wr = 0; bus_error = 0;
    rd(A_IS, rv); chk("R11 set wins over clear", rv, 14'h2000);
    wr(A_IE, 14'h2000);
    chk("R12 irq on bit13", irq, 1);
    clear_all();
    chk("R12 irq after clear", irq, 0);
    wr(A_IE, 14'h0);
  endtask

  task automatic t_timeout();
    rx_send(8'h55, 0, 0);
    tick(); tick(); tick();
    rd(A_IS, rv); chk("R9 no timeout at 3", rv[11], 0);
    rx_send(8'h56, 0, 0);
    tick(); tick(); tick();
    rd(A_IS, rv); chk("R9 restart by new char", rv[11], 0);
    tick();
    rd(A_IS, rv); chk("R9 timeout at 4", rv[11], 1);
    rd(A_RXQ, rv); rd(A_RXQ, rv);
    clear_all();
    tick(); tick(); tick(); tick();
    rd(A_IS, rv); chk("R9 empty no timeout", rv[11], 0);
  endtask

  task automatic t_flush();
    wr(A_TXQ, 14'h01); wr(A_TXQ, 14'h02);
    rx_send(8'h77, 0, 0);
    @(negedge clk); reg_wr = 1; reg_addr = A_FC; reg_wdata = 14'h5;
    @(negedge clk); reg_wr = 0; #1;
    chk("R13 tx flush reads 1", reg_rdata, 14'h5);
    @(negedge clk); #1;
    chk("R13 tx flush self-clears", reg_rdata, 14'h1);
    rd(A_IDX, rv); chk("R13 tx emptied rx kept", rv, 14'h0100);
    wr(A_FC, 14'h9);
    rd(A_IDX, rv); chk("R13 rx emptied", rv, 0);
    rd(A_FC, rv); chk("R13 enable kept", rv, 14'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_rx_full();
    t_irq_line();
    t_timeout();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule